// File: doc/BRIEF.md
# Sectioned Carry Select Adder

This block adds two 64-bit operands and an incoming carry, returning a 64-bit sum and an outgoing carry, with no clock and no stored state. The word is cut into a chain of ripple-carry sections whose widths come from a parameter list. The default list is uneven: narrow sections at the bottom, wider ones in the middle, and a slightly narrower one at the top.

The lowest section is a single ripple-carry chain fed by the external carry. Each higher section holds two identical ripple-carry chains on the same operand bits. One has its carry input tied low and the other tied high, and both start work as soon as the operands arrive. A 2:1 multiplexer then picks one of the two results, steered by the carry that the section below has already resolved. The carry that the top section resolves becomes the outgoing carry.

A width list that does not add up to the operand width stops elaboration with an error.

The block has no sequential logic, so the usual state-machine layout does not apply. It keeps the house naming and layout only.

Top module: `csa_adder64`

## Requirements
- R1: `{cout_o, sum_o}` equals the 65-bit value of `a_i + b_i + cin_i` for every defined input.
- R2: With the default list, the section widths from bit 0 upward are 5,5,5,6,6,7,7,8,8,7, so section boundaries sit at bits 5,10,15,21,27,34,41,49,57. A carry produced just below any boundary reaches the bit above it, so `(2^k - 1) + 1` gives `2^k`.
- R3: A build with `NUM_SECT = 8` and eight 8-bit sections gives results identical to the default build.
- R4: In every upper section, the candidate computed with carry-in high equals the candidate computed with carry-in low plus one, taken as a (width+1)-bit value.
- R5: The lowest section uses `cin_i` directly: `0 + 0 + 1` gives a sum of 1 and a carry-out of 0.
- R6: All-ones plus one gives a sum of 0 and a carry-out of 1. All-ones plus zero with carry-in 1 gives the same result.
- R7: Zero operands with carry-in 0 give a sum of 0 and a carry-out of 0.
- R8: The outputs carry no X or Z when all inputs are defined.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 64 | Sum bits |
| cout_o | output | 1 | Carry out of bit 63 |

## Verification
The bench builds two instances side by side and feeds them the same stimulus. One uses the default uneven ten-section list. The other uses a uniform list of eight 8-bit sections. Together they exercise both the narrow and the wide sections, and both arrangements of section boundaries. Directed carry chains are aimed at every boundary of both lists, which reaches every select multiplexer in both builds. Random operands then fill in the remaining behaviour of the multiplexer chain.

// File: rtl/csa_pkg.sv
package csa_pkg;
    // Bits per entry in a packed section-width list.
    localparam int unsigned FIELD_W = 8;

    // Majority function: carry out of a one-bit full adder.
    function automatic logic fa_carry(input logic x, input logic y, input logic c);
        return (x & y) | (c & (x ^ y));
    endfunction
endpackage

// File: rtl/csa_full_add.sv
module csa_full_add (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    import csa_pkg::*;

    assign s_o = x_i ^ y_i ^ c_i;
    assign c_o = fa_carry(x_i, y_i, c_i);
endmodule

// File: rtl/csa_ripple.sv
module csa_ripple #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] chain;

    assign chain[0] = cin_i;

    for (genvar k = 0; k < W; k++) begin : g_bit
        csa_full_add u_fa (
            .x_i (a_i[k]),
            .y_i (b_i[k]),
            .c_i (chain[k]),
            .s_o (sum_o[k]),
            .c_o (chain[k+1])
        );
    end

    assign cout_o = chain[W];

    // The bit-level chain must agree with a behavioural addition of its ports.
    always_comb begin
        AST_RIPPLE_ADD: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))  // R1
            else $error("ripple chain mismatch");
    end
endmodule

// File: rtl/csa_select_section.sv
module csa_select_section #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sel_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W-1:0] sum_lo, sum_hi;
    logic         co_lo, co_hi;

    // Candidate assuming no incoming carry.
    csa_ripple #(.W(W)) u_cand0 (
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (1'b0),
        .sum_o  (sum_lo),
        .cout_o (co_lo)
    );

    // Candidate assuming an incoming carry.
    csa_ripple #(.W(W)) u_cand1 (
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (1'b1),
        .sum_o  (sum_hi),
        .cout_o (co_hi)
    );

    // 2:1 pick steered by the carry resolved below.
    always_comb begin
        if (sel_i) begin
            sum_o  = sum_hi;
            cout_o = co_hi;
        end else begin
            sum_o  = sum_lo;
            cout_o = co_lo;
        end
    end

    always_comb begin
        AST_CAND_STEP: assert ({co_hi, sum_hi} == ({co_lo, sum_lo} + 1'b1))  // R4
            else $error("candidates differ by other than one");
        AST_CARRY_MONO: assert (!co_lo || co_hi)  // R4
            else $error("carry with cin=0 but not with cin=1");
    end
endmodule

// File: rtl/csa_adder64.sv
module csa_adder64 #(
    parameter int unsigned WIDTH    = 64,
    parameter int unsigned NUM_SECT = 10,
    parameter logic [NUM_SECT*csa_pkg::FIELD_W-1:0] SECT_LIST =
        {8'd7, 8'd8, 8'd8, 8'd7, 8'd7, 8'd6, 8'd6, 8'd5, 8'd5, 8'd5}
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    import csa_pkg::*;

    // Width of section idx; entry 0 is the least significant section.
    function automatic int unsigned sect_w(input int unsigned idx);
        return int'(SECT_LIST[idx*FIELD_W +: FIELD_W]);
    endfunction

    // Lowest bit position of section idx.
    function automatic int unsigned sect_lo(input int unsigned idx);
        int unsigned acc;
        acc = 0;
        for (int unsigned k = 0; k < idx; k++) acc += sect_w(k);
        return acc;
    endfunction

    function automatic bit any_zero_width();
        bit z;
        z = 1'b0;
        for (int unsigned k = 0; k < NUM_SECT; k++) if (sect_w(k) == 0) z = 1'b1;
        return z;
    endfunction

    localparam int unsigned LIST_TOTAL = sect_lo(NUM_SECT);
    localparam bit          LIST_EMPTY = any_zero_width();

    if (LIST_TOTAL != WIDTH) begin : g_bad_total
        $error("section widths do not add up to the operand width");
    end
    if (LIST_EMPTY) begin : g_bad_entry
        $error("section width list holds a zero entry");
    end

    logic [NUM_SECT:0] sect_carry;
    logic [WIDTH-1:0]  sum_w;

    assign sect_carry[0] = cin_i;

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
        localparam int unsigned SW = sect_w(g);
        localparam int unsigned LO = sect_lo(g);

        if (g == 0) begin : g_base
            csa_ripple #(.W(SW)) u_base (
                .a_i    (a_i[LO +: SW]),
                .b_i    (b_i[LO +: SW]),
                .cin_i  (sect_carry[0]),
                .sum_o  (sum_w[LO +: SW]),
                .cout_o (sect_carry[1])
            );
        end else begin : g_sel
            csa_select_section #(.W(SW)) u_sel (
                .a_i    (a_i[LO +: SW]),
                .b_i    (b_i[LO +: SW]),
                .sel_i  (sect_carry[g]),
                .sum_o  (sum_w[LO +: SW]),
                .cout_o (sect_carry[g+1])
            );
        end
    end

    assign sum_o  = sum_w;
    assign cout_o = sect_carry[NUM_SECT];

    always_comb begin
        AST_TOTAL_ADD: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))  // R1
            else $error("adder result mismatch");
        AST_NO_UNKNOWN: assert ($isunknown({a_i, b_i, cin_i}) || !$isunknown({cout_o, sum_o}))  // R8
            else $error("unknown output for defined inputs");
        AST_ZERO_IN: assert ((a_i != '0) || (b_i != '0) || cin_i || ((sum_o == '0) && !cout_o))  // R7
            else $error("zero operands gave nonzero result");
    end
endmodule

// File: tb/csa_adder64_tb_top.sv
module csa_adder64_tb_top;
    localparam int W = 64;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [W-1:0] a, b;
    logic         cin;
    logic [W-1:0] sum_def, sum_uni;
    logic         co_def, co_uni;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    csa_adder64 dut_i (
        .a_i (a), .b_i (b), .cin_i (cin),
        .sum_o (sum_def), .cout_o (co_def)
    );

    csa_adder64 #(
        .WIDTH    (64),
        .NUM_SECT (8),
        .SECT_LIST({8{8'd8}})
    ) dut_uni_i (
        .a_i (a), .b_i (b), .cin_i (cin),
        .sum_o (sum_uni), .cout_o (co_uni)
    );

    // Behavioural reference: plain 65-bit addition.
    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb,
                         input logic vc, input string req);
        logic [W:0] exp;
        @(posedge clk);
        a   = va;
        b   = vb;
        cin = vc;
        exp = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
        @(negedge clk);
        n_vec++;
        if ($isunknown({co_def, sum_def, co_uni, sum_uni})) begin
            n_fail++;
            $display("FAIL R8 (%s): unknown output def=%h_%h uni=%h_%h expected %h",
                     req, co_def, sum_def, co_uni, sum_uni, exp);
        end
        if ({co_def, sum_def} !== exp) begin
            n_fail++;
            $display("FAIL %s default build: actual %h_%h expected %h",
                     req, co_def, sum_def, exp);
        end
        if ({co_uni, sum_uni} !== exp) begin
            n_fail++;
            $display("FAIL R3/%s uniform build: actual %h_%h expected %h",
                     req, co_uni, sum_uni, exp);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int bounds_def [9] = '{5, 10, 15, 21, 27, 34, 41, 49, 57};
        a = '0; b = '0; cin = 1'b0;

        apply('0, '0, 1'b0, "R7");                       // zero operands
        apply('0, '0, 1'b1, "R5");                       // carry-in alone
        apply('1, 64'd1, 1'b0, "R6");                    // all ones plus one
        apply('1, '0, 1'b1, "R6");                       // all ones plus carry-in
        apply('1, '1, 1'b1, "R1");                       // largest sum

        // Carry produced just below each default boundary.
        for (int i = 0; i < 9; i++) begin
            logic [W-1:0] m;
            m = (64'd1 << bounds_def[i]) - 64'd1;
            apply(m, 64'd1, 1'b0, "R2");
            apply(m, '0, 1'b1, "R2");
        end

        // Carry produced just below each uniform boundary.
        for (int k = 8; k < 64; k += 8) begin
            logic [W-1:0] m;
            m = (64'd1 << k) - 64'd1;
            apply(m, 64'd1, 1'b0, "R3");
        end

        // Alternating patterns: propagate in every bit.
        apply(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1, "R1");
        apply(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, "R1");
        apply(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, "R1");

        // Random operands.
        for (int i = 0; i < 2000; i++) begin
            apply({$urandom(), $urandom()}, {$urandom(), $urandom()},
                  1'($urandom() & 1), "R1");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule